// File: doc/BRIEF.md
# Line Fetch Unit with Next-Line Predictor

This unit walks an instruction stream one memory line at a time. It keeps a fetch pointer and issues one line request to instruction memory. When the matching line comes back, the unit passes it on as a bundle. Each bundle carries the current restart generation, the line's own address, the whole line of data and a guess at the line that follows. The unit then moves its fetch pointer to that guess and requests the next line.

A redirect input lets the downstream decoder steer fetch. A redirect gives a new generation number, the line address that the redirect came from and the line to fetch next. It loads the fetch pointer and forgets any request in flight. It also trains a small direct-mapped next-line table. A redirect that lands on a distant line records a from-to link. A redirect that lands on the same line or the next line removes the link for the source line. Later bundles for a linked line predict the recorded target. All other lines predict the next sequential line.

Top module: `line_fetch_unit`

## Requirements
- R1: After reset the generation and fetch pointer are zero and no request is pending, so `mem_cmd_valid` is 1 with `mem_cmd_line` 0, `bnd_valid` is 0 and `mem_rsp_ready` is 1.
- R2: At most one request is in flight. After a command is accepted, `mem_cmd_valid` stays 0 until a bundle is taken or a redirect arrives.
- R3: A redirect loads the generation from `redir_gen` and the fetch pointer from `redir_to_line`, and it clears the pending request. In the same cycle `mem_cmd_valid` is 1 with `mem_cmd_line` equal to `redir_to_line`.
- R4: While a request is pending, `mem_rsp_ready` follows `bnd_ready`, so a response is consumed only when the bundle side can take it.
- R5: A consumed response whose line differs from the fetch pointer produces no bundle, and the request stays pending.
- R6: While no request is pending, `mem_rsp_ready` is 1 and any response is dropped without a bundle.
- R7: A bundle carries the current generation, the fetch pointer as its line, and the response data unchanged.
- R8: A bundle's next line is the table target on a hit, or its line plus one on a miss. Once the bundle is taken, the fetch pointer moves to that next line.
- R9: A redirect whose target is neither the source line nor the source line plus one records source to target in table slot `source[3:0]`.
- R10: A redirect whose target is the source line or the source line plus one clears slot `source[3:0]`, but only when that slot's tag equals the source line.
- R11: The table has 16 slots indexed by line bits [3:0], each with a valid bit and a full 32-bit tag. A line whose slot holds another tag misses.
- R12: A redirect wins over a response in the same cycle. No bundle is produced, and the response is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Redirect present this cycle (always accepted) |
| redir_gen | input | 8 | New generation number |
| redir_from_line | input | 32 | Line the redirect came from |
| redir_to_line | input | 32 | Line to fetch next |
| mem_cmd_valid | output | 1 | Line request valid |
| mem_cmd_ready | input | 1 | Memory accepts request |
| mem_cmd_line | output | 32 | Requested line address |
| mem_rsp_valid | input | 1 | Returned line valid |
| mem_rsp_ready | output | 1 | Unit consumes returned line |
| mem_rsp_line | input | 32 | Address of returned line |
| mem_rsp_data | input | 512 | Returned line data (64 bytes) |
| bnd_valid | output | 1 | Bundle valid |
| bnd_ready | input | 1 | Downstream takes bundle |
| bnd_gen | output | 8 | Bundle generation |
| bnd_line | output | 32 | Bundle line address |
| bnd_next_line | output | 32 | Predicted following line |
| bnd_data | output | 512 | Bundle line data |

## Verification
A redirect and a returning response can arrive in the same cycle. A redirect can also meet a bundle handoff that would train the pointer. The bench creates this case directly by holding a matching response on the return port while it pulses a redirect. It then checks that no bundle appears, that the response is consumed, and that the next request targets the redirect line. The random phase raises redirects about one cycle in twelve while responses arrive. A cycle-level model in the bench judges every cycle's outputs against the inputs, including the table contents that earlier redirects left behind.

// File: rtl/lf_pkg.sv
package lf_pkg;
    localparam int LF_ADDR_W      = 32;
    localparam int LF_GEN_W       = 8;
    localparam int LF_LINE_BYTES  = 64;
    localparam int LF_TABLE_DEPTH = 16;
endpackage

// File: rtl/lf_next_line_table.sv
module lf_next_line_table #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              train_valid,
    input  logic [ADDR_W-1:0] train_from,
    input  logic [ADDR_W-1:0] train_to,
    input  logic [ADDR_W-1:0] lookup_line,
    output logic              lookup_hit,
    output logic [ADDR_W-1:0] lookup_target
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    logic [DEPTH-1:0]  valid_q, valid_d;
    logic [ADDR_W-1:0] tag_q [DEPTH];
    logic [ADDR_W-1:0] tag_d [DEPTH];
    logic [ADDR_W-1:0] tgt_q [DEPTH];
    logic [ADDR_W-1:0] tgt_d [DEPTH];

    logic [IDX_W-1:0] tr_idx, lk_idx;
    logic             tr_local;

    assign tr_idx   = train_from[IDX_W-1:0];
    assign lk_idx   = lookup_line[IDX_W-1:0];
    assign tr_local = (train_to == train_from) || (train_to == train_from + STEP);

    always_comb begin
        valid_d = valid_q;
        for (int i = 0; i < DEPTH; i++) begin
            tag_d[i] = tag_q[i];
            tgt_d[i] = tgt_q[i];
        end
        if (train_valid) begin
            if (tr_local) begin
                if (valid_q[tr_idx] && tag_q[tr_idx] == train_from)
                    valid_d[tr_idx] = 1'b0;
            end else begin
                valid_d[tr_idx] = 1'b1;
                tag_d[tr_idx]   = train_from;
                tgt_d[tr_idx]   = train_to;
            end
        end
    end

    assign lookup_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lookup_line);
    assign lookup_target = tgt_q[lk_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            tag_q[g] <= tag_d[g];
            tgt_q[g] <= tgt_d[g];
        end
    end

    assert_train_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (train_valid && !tr_local) |=>
            (valid_q[$past(tr_idx)] && tag_q[$past(tr_idx)] == $past(train_from)
             && tgt_q[$past(tr_idx)] == $past(train_to)));

    assert_train_erase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (train_valid && tr_local && valid_q[tr_idx] && tag_q[tr_idx] == train_from)
            |=> !valid_q[$past(tr_idx)]);
endmodule

// File: rtl/lf_fetch_ctrl.sv
module lf_fetch_ctrl #(
    parameter int ADDR_W = 32,
    parameter int GEN_W  = 8,
    parameter int DATA_W = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redir_valid,
    input  logic [GEN_W-1:0]  redir_gen,
    input  logic [ADDR_W-1:0] redir_to_line,
    output logic              mem_cmd_valid,
    input  logic              mem_cmd_ready,
    output logic [ADDR_W-1:0] mem_cmd_line,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    input  logic [ADDR_W-1:0] mem_rsp_line,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              bnd_valid,
    input  logic              bnd_ready,
    output logic [GEN_W-1:0]  bnd_gen,
    output logic [ADDR_W-1:0] bnd_line,
    output logic [ADDR_W-1:0] bnd_next_line,
    output logic [DATA_W-1:0] bnd_data,
    output logic [ADDR_W-1:0] lookup_line,
    input  logic              lookup_hit,
    input  logic [ADDR_W-1:0] lookup_target
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    typedef struct packed {
        logic [GEN_W-1:0]  gen;
        logic [ADDR_W-1:0] ptr;
        logic              pend;
    } fetch_state_t;

    fetch_state_t st_q, st_d, st;

    always_comb begin
        st = st_q;
        if (redir_valid) begin
            st.gen  = redir_gen;
            st.ptr  = redir_to_line;
            st.pend = 1'b0;
        end
        lookup_line   = st.ptr;
        mem_rsp_ready = !st.pend || bnd_ready;
        bnd_valid     = st.pend && mem_rsp_valid && (mem_rsp_line == st.ptr);
        bnd_gen       = st.gen;
        bnd_line      = st.ptr;
        bnd_data      = mem_rsp_data;
        bnd_next_line = lookup_hit ? lookup_target : st.ptr + STEP;
        if (bnd_valid && bnd_ready) begin
            st.ptr  = bnd_next_line;
            st.pend = 1'b0;
        end
        mem_cmd_valid = !st.pend;
        mem_cmd_line  = st.ptr;
        if (mem_cmd_valid && mem_cmd_ready)
            st.pend = 1'b1;
        st_d = st;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_cmd_marks_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && mem_cmd_ready) |=> st_q.pend);

    assert_redirect_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> (st_q.gen == $past(redir_gen)
                         && (st_q.ptr == $past(redir_to_line))));

    assert_idle_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pend |-> mem_rsp_ready);

    assert_pointer_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_valid && bnd_ready) |=> st_q.ptr == $past(bnd_next_line));

    assert_redirect_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> !bnd_valid);
endmodule

// File: rtl/line_fetch_unit.sv
module line_fetch_unit
    import lf_pkg::*;
#(
    parameter int ADDR_W      = LF_ADDR_W,
    parameter int GEN_W       = LF_GEN_W,
    parameter int LINE_BYTES  = LF_LINE_BYTES,
    parameter int TABLE_DEPTH = LF_TABLE_DEPTH,
    localparam int DATA_W     = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redir_valid,
    input  logic [GEN_W-1:0]  redir_gen,
    input  logic [ADDR_W-1:0] redir_from_line,
    input  logic [ADDR_W-1:0] redir_to_line,
    output logic              mem_cmd_valid,
    input  logic              mem_cmd_ready,
    output logic [ADDR_W-1:0] mem_cmd_line,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    input  logic [ADDR_W-1:0] mem_rsp_line,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              bnd_valid,
    input  logic              bnd_ready,
    output logic [GEN_W-1:0]  bnd_gen,
    output logic [ADDR_W-1:0] bnd_line,
    output logic [ADDR_W-1:0] bnd_next_line,
    output logic [DATA_W-1:0] bnd_data
);
    logic [ADDR_W-1:0] lookup_line, lookup_target;
    logic              lookup_hit;

    lf_fetch_ctrl #(.ADDR_W(ADDR_W), .GEN_W(GEN_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .redir_valid(redir_valid), .redir_gen(redir_gen), .redir_to_line(redir_to_line),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready), .mem_cmd_line(mem_cmd_line),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
        .mem_rsp_line(mem_rsp_line), .mem_rsp_data(mem_rsp_data),
        .bnd_valid(bnd_valid), .bnd_ready(bnd_ready), .bnd_gen(bnd_gen),
        .bnd_line(bnd_line), .bnd_next_line(bnd_next_line), .bnd_data(bnd_data),
        .lookup_line(lookup_line), .lookup_hit(lookup_hit), .lookup_target(lookup_target)
    );

    lf_next_line_table #(.ADDR_W(ADDR_W), .DEPTH(TABLE_DEPTH)) u_table (
        .clk(clk), .rst_n(rst_n),
        .train_valid(redir_valid), .train_from(redir_from_line), .train_to(redir_to_line),
        .lookup_line(lookup_line), .lookup_hit(lookup_hit), .lookup_target(lookup_target)
    );
endmodule

// File: tb/line_fetch_unit_test.sv
module line_fetch_unit_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         redir_valid = 1'b0;
    logic [7:0]   redir_gen = '0;
    logic [31:0]  redir_from_line = '0, redir_to_line = '0;
    logic         mem_cmd_valid, mem_cmd_ready = 1'b0;
    logic [31:0]  mem_cmd_line;
    logic         mem_rsp_valid = 1'b0, mem_rsp_ready;
    logic [31:0]  mem_rsp_line = '0;
    logic [511:0] mem_rsp_data = '0;
    logic         bnd_valid, bnd_ready = 1'b0;
    logic [7:0]   bnd_gen;
    logic [31:0]  bnd_line, bnd_next_line;
    logic [511:0] bnd_data;

    always #10 clk = ~clk;

    line_fetch_unit uut (.*);

    int tests = 0, fails = 0;

    // bench model state
    logic [7:0]  m_gen;
    logic [31:0] m_ptr;
    logic        m_pend;
    logic        t_v [16];
    logic [31:0] t_tag [16];
    logic [31:0] t_tgt [16];

    // memory side
    logic        mem_busy = 1'b0;
    logic [31:0] mem_line = '0;

    // last observed outputs
    logic        o_cv, o_rr, o_bv;
    logic [31:0] o_cl, o_next;

    function automatic logic [511:0] line_pattern(input logic [31:0] l);
        logic [511:0] r;
        for (int k = 0; k < 16; k++) r[k*32 +: 32] = l + 32'h0101_0101 * k + 32'h5A00_00C3;
        return r;
    endfunction

    function automatic logic [31:0] predict(input logic [31:0] l);
        if (t_v[l[3:0]] && t_tag[l[3:0]] == l) return t_tgt[l[3:0]];
        return l + 32'd1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input bit rv, input logic [7:0] rg, input logic [31:0] rf,
                        input logic [31:0] rt, input bit cr, input bit sv,
                        input logic [31:0] sl, input bit br);
        logic [7:0]  g1;
        logic [31:0] p1, nx, p2;
        logic        e1, ebv, err, fire, e2;
        @(negedge clk);
        redir_valid = rv; redir_gen = rg; redir_from_line = rf; redir_to_line = rt;
        mem_cmd_ready = cr; mem_rsp_valid = sv; mem_rsp_line = sl;
        mem_rsp_data = line_pattern(sl); bnd_ready = br;
        #2;
        g1 = rv ? rg : m_gen; p1 = rv ? rt : m_ptr; e1 = rv ? 1'b0 : m_pend;
        err = !e1 || br;
        ebv = e1 && sv && (sl == p1);
        nx = predict(p1);
        fire = ebv && br;
        e2 = e1 && !fire;
        p2 = fire ? nx : p1;
        o_cv = mem_cmd_valid; o_cl = mem_cmd_line; o_rr = mem_rsp_ready;
        o_bv = bnd_valid; o_next = bnd_next_line;
        chk(mem_cmd_valid == !e2, "R2", "cmd_valid", 64'(mem_cmd_valid), 64'(!e2));
        if (!e2) chk(mem_cmd_line == p2, "R3", "cmd_line", 64'(mem_cmd_line), 64'(p2));
        chk(mem_rsp_ready == err, "R4", "rsp_ready", 64'(mem_rsp_ready), 64'(err));
        chk(bnd_valid == ebv, "R5", "bnd_valid", 64'(bnd_valid), 64'(ebv));
        if (ebv) begin
            chk(bnd_gen == g1, "R7", "bnd_gen", 64'(bnd_gen), 64'(g1));
            chk(bnd_line == p1, "R7", "bnd_line", 64'(bnd_line), 64'(p1));
            chk(bnd_data == line_pattern(sl), "R7", "bnd_data",
                bnd_data[63:0], line_pattern(sl) >> 0);
            chk(bnd_next_line == nx, "R8", "bnd_next", 64'(bnd_next_line), 64'(nx));
        end
        // model update at the coming edge
        if (rv) begin
            if (rt == rf || rt == rf + 32'd1) begin
                if (t_v[rf[3:0]] && t_tag[rf[3:0]] == rf) t_v[rf[3:0]] = 1'b0;
            end else begin
                t_v[rf[3:0]] = 1'b1; t_tag[rf[3:0]] = rf; t_tgt[rf[3:0]] = rt;
            end
        end
        m_gen = g1; m_ptr = p2; m_pend = e2 || (!e2 && cr);
        // memory side bookkeeping
        if (sv && o_rr && mem_busy && sl == mem_line) mem_busy = 1'b0;
        if (o_cv && cr) begin mem_busy = 1'b1; mem_line = o_cl; end
    endtask

    task automatic idle_step();
        step(0, 8'd0, 32'd0, 32'd0, 0, 0, 32'd0, 0);
    endtask

    task automatic redirect(input logic [7:0] g, input logic [31:0] f, input logic [31:0] t);
        step(1, g, f, t, 0, 0, 32'd0, 0);
    endtask

    // issue a request for the current pointer, then return it
    task automatic fetch_current(input logic [31:0] l);
        step(0, 8'd0, 32'd0, 32'd0, 1, 0, 32'd0, 0);
        step(0, 8'd0, 32'd0, 32'd0, 0, 1, l, 1);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_gen = '0; m_ptr = '0; m_pend = 1'b0;
        for (int i = 0; i < 16; i++) begin t_v[i] = 1'b0; t_tag[i] = '0; t_tgt[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #2;
        // R1 reset state
        chk(mem_cmd_valid == 1'b1, "R1", "cmd_valid", 64'(mem_cmd_valid), 64'd1);
        chk(mem_cmd_line == 32'd0, "R1", "cmd_line", 64'(mem_cmd_line), 64'd0);
        chk(bnd_valid == 1'b0, "R1", "bnd_valid", 64'(bnd_valid), 64'd0);
        chk(mem_rsp_ready == 1'b1, "R1", "rsp_ready", 64'(mem_rsp_ready), 64'd1);

        // R2: request in flight blocks further commands
        step(0, 8'd0, 32'd0, 32'd0, 1, 0, 32'd0, 0);
        step(0, 8'd0, 32'd0, 32'd0, 1, 0, 32'd0, 0);
        chk(o_cv == 1'b0, "R2", "second cmd", 64'(o_cv), 64'd0);
        // R5: wrong line consumed, no bundle, still pending
        step(0, 8'd0, 32'd0, 32'd0, 1, 1, 32'd5, 1);
        chk(o_rr == 1'b1 && o_bv == 1'b0, "R5", "mismatch", {o_rr, o_bv}, 64'b10);
        idle_step();
        chk(o_cv == 1'b0, "R5", "still pending", 64'(o_cv), 64'd0);
        // R4: bundle side stalled
        step(0, 8'd0, 32'd0, 32'd0, 0, 1, 32'd0, 0);
        chk(o_rr == 1'b0, "R4", "rsp_ready stalled", 64'(o_rr), 64'd0);
        step(0, 8'd0, 32'd0, 32'd0, 0, 1, 32'd0, 1);
        chk(o_bv && o_next == 32'd1, "R8", "sequential next", 64'(o_next), 64'd1);

        // R9 link then hit
        redirect(8'd1, 32'h10, 32'h90);
        redirect(8'd2, 32'h05, 32'h10);
        chk(o_cv && o_cl == 32'h10, "R3", "redirect cmd line", 64'(o_cl), 64'h10);
        fetch_current(32'h10);
        chk(o_bv && o_next == 32'h90, "R9", "linked next", 64'(o_next), 64'h90);
        // R10 erase by local redirect
        redirect(8'd3, 32'h10, 32'h11);
        redirect(8'd4, 32'h07, 32'h10);
        fetch_current(32'h10);
        chk(o_bv && o_next == 32'h11, "R10", "erased next", 64'(o_next), 64'h11);
        // R11 tag mismatch in shared slot
        redirect(8'd5, 32'h20, 32'h40);
        redirect(8'd6, 32'h09, 32'h30);
        fetch_current(32'h30);
        chk(o_bv && o_next == 32'h31, "R11", "tag miss", 64'(o_next), 64'h31);
        // R10 erase ignored for foreign tag
        redirect(8'd7, 32'h30, 32'h31);
        redirect(8'd8, 32'h0b, 32'h20);
        fetch_current(32'h20);
        chk(o_bv && o_next == 32'h40, "R10", "foreign erase kept", 64'(o_next), 64'h40);

        // R6: nothing pending, response dropped
        redirect(8'd9, 32'h01, 32'h70);
        step(0, 8'd0, 32'd0, 32'd0, 0, 1, 32'h70, 1);
        chk(o_rr == 1'b1 && o_bv == 1'b0, "R6", "idle drop", {o_rr, o_bv}, 64'b10);
        // R12: redirect alongside matching response
        step(0, 8'd0, 32'd0, 32'd0, 1, 0, 32'd0, 0);
        step(1, 8'd10, 32'h70, 32'h3, 0, 1, 32'h70, 1);
        chk(o_bv == 1'b0 && o_rr == 1'b1, "R12", "redirect wins", {o_bv, o_rr}, 64'b01);
        chk(o_cv && o_cl == 32'h3, "R12", "new target", 64'(o_cl), 64'h3);

        // random phase
        mem_busy = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            bit rv, cr, sv, br;
            logic [31:0] rf, rt, sl;
            rv = ($urandom % 100) < 8;
            rf = $urandom % 48;
            case ($urandom % 6)
                0, 1: rt = rf + 32'd1;
                2:    rt = rf;
                default: rt = $urandom % 48;
            endcase
            cr = ($urandom % 100) < 70;
            br = ($urandom % 100) < 70;
            sv = 1'b0; sl = '0;
            if (mem_busy && ($urandom % 100) < 50) begin sv = 1'b1; sl = mem_line; end
            else if (($urandom % 100) < 5) begin sv = 1'b1; sl = $urandom % 48; end
            step(rv, 8'($urandom), rf, rt, cr, sv, sl, br);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule